// File: doc/BRIEF.md
# Unordered Operand-Ready Issue Queue

This block holds renamed integer instructions until their source operands are available. It has sixteen slots and keeps no program order. An instruction enters the lowest free slot it can get. It carries the physical tags of up to three sources, one ready bit per source, its destination tag, an opcode and its active-list tag. Result tags broadcast on writeback are compared against every waiting source, and a match sets that source's ready bit.

Each cycle the queue picks up to two entries whose sources are all ready and hands them to two execution lanes. The lowest-numbered ready slot goes to lane 0 and the next one to lane 1. An issued slot becomes free at the next clock edge.

After a mispredicted branch, a flush removes every entry that is younger than the branch. Age is measured from the current active-list head, modulo 32. Rename logic sits upstream of the queue and the execution units sit downstream. It accepts two instructions per cycle only when at least two slots are free.

Top module: `iq_issue_queue`

## Requirements
- R1: After reset no slot is occupied, `iss_valid` is 0 and `disp_ready` is 1.
- R2: Dispatch lane 0 is written into the lowest free slot and lane 1 into the next free slot. `disp_ready` is 1 exactly when at least two slots are free.
- R3: An entry issues only when all three of its source ready bits are set. Unused sources are presented with their ready bit set to 1.
- R4: A broadcast whose tag matches a waiting source sets that source's ready bit. The entry can then issue in the following cycle.
- R5: A broadcast in the same cycle that an instruction is dispatched, with a tag equal to one of its sources, makes that source ready on entry.
- R6: At most two entries issue per cycle. `iss_valid[0]` selects the lowest-numbered ready slot and `iss_valid[1]` the second lowest. `iss_valid[1]` is never set without `iss_valid[0]`. The opcode, sources, destination and active-list tag of each selected entry appear on that lane's outputs.
- R7: An issued entry leaves the queue at the next clock edge and never issues twice. Its slot can take a new instruction from the following cycle on.
- R8: When `flush_valid` is 1, every entry whose distance `(tag - al_head) mod 32` is greater than `(flush_tag - al_head) mod 32` is removed. Older entries and the branch's own entry stay.
- R9: Dispatch in a flush cycle is dropped. Issue in a flush cycle comes only from entries that survive the flush.
- R10: Dispatch offered while `disp_ready` is 0 writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 2 | Dispatch request per lane |
| disp_ready | output | 1 | At least two free slots |
| disp_op | input | 2x8 | Opcode per lane |
| disp_src | input | 2x3x6 | Source physical tags per lane |
| disp_src_rdy | input | 2x3 | Source ready bits from the busy table |
| disp_dst | input | 2x6 | Destination physical tag per lane |
| disp_alt | input | 2x5 | Active-list tag per lane |
| wb_valid | input | 2 | Result broadcast valid per writeback port |
| wb_tag | input | 2x6 | Broadcast result tag |
| flush_valid | input | 1 | Remove entries younger than `flush_tag` |
| flush_tag | input | 5 | Active-list tag of the mispredicted branch |
| al_head | input | 5 | Active-list tag of the oldest instruction in flight |
| iss_valid | output | 2 | Issue valid per execution lane |
| iss_op | output | 2x8 | Issued opcode |
| iss_src | output | 2x3x6 | Issued source tags |
| iss_dst | output | 2x6 | Issued destination tag |
| iss_alt | output | 2x5 | Issued active-list tag |

## Verification
The assertions assume that the rename stage never offers a dispatch the queue has refused, and never expects a write during a flush. They also assume that the execution lanes always accept what is issued, since there is no issue back-pressure.

The stimulus drives dispatch only while `disp_ready` is seen high, with one deliberate exception in the stall test. It keeps `al_head` fixed within each test. Every active-list tag it gives is distinct, so flush age comparisons have one answer.

// File: rtl/iq_pkg.sv
package iq_pkg;
  localparam int TAG_W = 6;
  localparam int ALT_W = 5;
  localparam int OP_W  = 8;
  localparam int NSRC  = 3;

  typedef struct packed {
    logic [OP_W-1:0]             op;
    logic [NSRC-1:0][TAG_W-1:0]  src;
    logic [NSRC-1:0]             rdy;
    logic [TAG_W-1:0]            dst;
    logic [ALT_W-1:0]            alt;
  } iq_ent_t;

  // true when tag lies further from the head than the branch tag
  function automatic logic iq_younger(input logic [ALT_W-1:0] tag,
                                      input logic [ALT_W-1:0] brt,
                                      input logic [ALT_W-1:0] head);
    logic [ALT_W-1:0] dist_tag;
    logic [ALT_W-1:0] dist_brt;
    dist_tag = tag - head;
    dist_brt = brt - head;
    return dist_tag > dist_brt;
  endfunction
endpackage

// File: rtl/iq_pick.sv
// Finds the PICKS lowest-numbered set bits of a request vector.
module iq_pick #(
  parameter int N     = 16,
  parameter int PICKS = 2,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]                  req,
  output logic [PICKS-1:0]              found,
  output logic [PICKS-1:0][IDX_W-1:0]   idx
);
  logic [N-1:0] rest;

  always_comb begin
    found = '0;
    idx   = '0;
    rest  = req;
    for (int k = 0; k < PICKS; k++) begin
      for (int i = N - 1; i >= 0; i--) begin
        if (rest[i]) begin
          found[k] = 1'b1;
          idx[k]   = i[IDX_W-1:0];
        end
      end
      if (found[k]) rest[idx[k]] = 1'b0;
    end
  end
endmodule

// File: rtl/iq_slot.sv
// One queue slot: storage, wakeup comparators and valid bit.
module iq_slot import iq_pkg::*; #(
  parameter int NWB = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  iq_ent_t                    wr_ent,
  input  logic                       clr,
  input  logic [NWB-1:0]             wb_valid,
  input  logic [NWB-1:0][TAG_W-1:0]  wb_tag,
  output logic                       valid_o,
  output logic                       ready_o,
  output iq_ent_t                    ent_o
);
  logic    valid_q, valid_n;
  iq_ent_t ent_q, ent_n;
  logic    ent_en;

  always_comb begin
    ent_n   = ent_q;
    valid_n = valid_q;
    for (int s = 0; s < NSRC; s++) begin
      for (int w = 0; w < NWB; w++) begin
        if (wb_valid[w] && (wb_tag[w] == ent_q.src[s])) ent_n.rdy[s] = 1'b1;
      end
    end
    if (clr) valid_n = 1'b0;
    if (wr_en) begin
      valid_n = 1'b1;
      ent_n   = wr_ent;
    end
  end

  assign ent_en = wr_en | valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_n;
  end

  always_ff @(posedge clk) begin
    if (ent_en) ent_q <= ent_n;
  end

  assign valid_o = valid_q;
  assign ready_o = valid_q & (&ent_q.rdy);
  assign ent_o   = ent_q;
endmodule

// File: rtl/iq_issue_queue.sv
module iq_issue_queue import iq_pkg::*; #(
  parameter int DEPTH  = 16,
  parameter int NWB    = 2,
  parameter int DISP_W = 2,
  parameter int ISS_W  = 2
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [DISP_W-1:0]                      disp_valid,
  output logic                                   disp_ready,
  input  logic [DISP_W-1:0][OP_W-1:0]            disp_op,
  input  logic [DISP_W-1:0][NSRC-1:0][TAG_W-1:0] disp_src,
  input  logic [DISP_W-1:0][NSRC-1:0]            disp_src_rdy,
  input  logic [DISP_W-1:0][TAG_W-1:0]           disp_dst,
  input  logic [DISP_W-1:0][ALT_W-1:0]           disp_alt,
  input  logic [NWB-1:0]                         wb_valid,
  input  logic [NWB-1:0][TAG_W-1:0]              wb_tag,
  input  logic                                   flush_valid,
  input  logic [ALT_W-1:0]                       flush_tag,
  input  logic [ALT_W-1:0]                       al_head,
  output logic [ISS_W-1:0]                       iss_valid,
  output logic [ISS_W-1:0][OP_W-1:0]             iss_op,
  output logic [ISS_W-1:0][NSRC-1:0][TAG_W-1:0]  iss_src,
  output logic [ISS_W-1:0][TAG_W-1:0]            iss_dst,
  output logic [ISS_W-1:0][ALT_W-1:0]            iss_alt
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DEPTH-1:0]              slot_valid;
  logic [DEPTH-1:0]              slot_ready;
  logic [DEPTH-1:0]              slot_kill;
  logic [DEPTH-1:0]              slot_iss;
  logic [DEPTH-1:0]              slot_wr;
  iq_ent_t [DEPTH-1:0]           slot_ent;
  iq_ent_t [DEPTH-1:0]           slot_wr_ent;
  iq_ent_t [DISP_W-1:0]          lane_ent;

  logic [DISP_W-1:0]             free_found;
  logic [DISP_W-1:0][IDX_W-1:0]  free_idx;
  logic [ISS_W-1:0]              rd_found;
  logic [ISS_W-1:0][IDX_W-1:0]   rd_idx;
  logic [DISP_W-1:0]             disp_acc;
  logic [CNT_W-1:0]              free_cnt;

  // free-slot count drives the dispatch handshake
  always_comb begin
    free_cnt = '0;
    for (int i = 0; i < DEPTH; i++) free_cnt = free_cnt + CNT_W'(!slot_valid[i]);
  end
  assign disp_ready = (free_cnt >= CNT_W'(DISP_W));

  // flush age compare, one per slot
  for (genvar i = 0; i < DEPTH; i++) begin : g_kill
    assign slot_kill[i] = flush_valid & slot_valid[i] &
                          iq_younger(slot_ent[i].alt, flush_tag, al_head);
  end

  iq_pick #(.N(DEPTH), .PICKS(DISP_W)) u_free_pick (
    .req   (~slot_valid),
    .found (free_found),
    .idx   (free_idx)
  );

  iq_pick #(.N(DEPTH), .PICKS(ISS_W)) u_ready_pick (
    .req   (slot_ready & ~slot_kill),
    .found (rd_found),
    .idx   (rd_idx)
  );

  // build incoming entries, folding in same-cycle broadcasts
  for (genvar l = 0; l < DISP_W; l++) begin : g_lane
    assign disp_acc[l] = disp_valid[l] & disp_ready & ~flush_valid & free_found[l];
    always_comb begin
      lane_ent[l].op  = disp_op[l];
      lane_ent[l].src = disp_src[l];
      lane_ent[l].dst = disp_dst[l];
      lane_ent[l].alt = disp_alt[l];
      lane_ent[l].rdy = disp_src_rdy[l];
      for (int s = 0; s < NSRC; s++) begin
        for (int w = 0; w < NWB; w++) begin
          if (wb_valid[w] && (wb_tag[w] == disp_src[l][s])) lane_ent[l].rdy[s] = 1'b1;
        end
      end
    end
  end

  // per-slot write and clear steering
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_comb begin
      slot_wr[i]     = 1'b0;
      slot_wr_ent[i] = lane_ent[0];
      for (int l = 0; l < DISP_W; l++) begin
        if (disp_acc[l] && (free_idx[l] == IDX_W'(i))) begin
          slot_wr[i]     = 1'b1;
          slot_wr_ent[i] = lane_ent[l];
        end
      end
      slot_iss[i] = 1'b0;
      for (int k = 0; k < ISS_W; k++) begin
        if (rd_found[k] && (rd_idx[k] == IDX_W'(i))) slot_iss[i] = 1'b1;
      end
    end

    iq_slot #(.NWB(NWB)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (slot_wr[i]),
      .wr_ent   (slot_wr_ent[i]),
      .clr      (slot_iss[i] | slot_kill[i]),
      .wb_valid (wb_valid),
      .wb_tag   (wb_tag),
      .valid_o  (slot_valid[i]),
      .ready_o  (slot_ready[i]),
      .ent_o    (slot_ent[i])
    );
  end

  // issue lanes read the selected slots
  for (genvar k = 0; k < ISS_W; k++) begin : g_iss
    assign iss_valid[k] = rd_found[k];
    assign iss_op[k]    = slot_ent[rd_idx[k]].op;
    assign iss_src[k]   = slot_ent[rd_idx[k]].src;
    assign iss_dst[k]   = slot_ent[rd_idx[k]].dst;
    assign iss_alt[k]   = slot_ent[rd_idx[k]].alt;
  end
endmodule

// File: rtl/iq_issue_queue_chk.sv
module iq_issue_queue_chk #(
  parameter int DEPTH  = 16,
  parameter int DISP_W = 2,
  parameter int ISS_W  = 2,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic [DISP_W-1:0]               disp_valid,
  input logic                            disp_ready,
  input logic                            flush_valid,
  input logic [ISS_W-1:0]                iss_valid,
  input logic [DEPTH-1:0]                slot_valid,
  input logic [ISS_W-1:0][IDX_W-1:0]     rd_idx,
  input logic [DISP_W-1:0][IDX_W-1:0]    free_idx,
  input logic [DISP_W-1:0]               disp_acc
);
  logic reuse_clash;
  always_comb begin
    reuse_clash = 1'b0;
    for (int k = 0; k < ISS_W; k++)
      for (int l = 0; l < DISP_W; l++)
        if (iss_valid[k] && disp_acc[l] && (rd_idx[k] == free_idx[l])) reuse_clash = 1'b1;
  end

  a_r6_lane_order: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid[1] |-> iss_valid[0]);

  a_r6_distinct_slots: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid[1] && iss_valid[0]) |-> (rd_idx[0] < rd_idx[1]));

  a_r7_no_reuse_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    !reuse_clash);

  a_r9_flush_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |=> ($countones(slot_valid) <= $past($countones(slot_valid))));

  a_r10_stall_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
    ((disp_valid != '0) && !disp_ready) |=> ($countones(slot_valid) <= $past($countones(slot_valid))));
endmodule

bind iq_issue_queue iq_issue_queue_chk #(.DEPTH(DEPTH), .DISP_W(DISP_W), .ISS_W(ISS_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .disp_valid  (disp_valid),
  .disp_ready  (disp_ready),
  .flush_valid (flush_valid),
  .iss_valid   (iss_valid),
  .slot_valid  (slot_valid),
  .rd_idx      (rd_idx),
  .free_idx    (free_idx),
  .disp_acc    (disp_acc)
);

// File: tb/iq_issue_queue_tb.sv
module iq_issue_queue_tb;
  import iq_pkg::*;

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0]                       disp_valid;
  logic                             disp_ready;
  logic [1:0][OP_W-1:0]             disp_op;
  logic [1:0][NSRC-1:0][TAG_W-1:0]  disp_src;
  logic [1:0][NSRC-1:0]             disp_src_rdy;
  logic [1:0][TAG_W-1:0]            disp_dst;
  logic [1:0][ALT_W-1:0]            disp_alt;
  logic [1:0]                       wb_valid;
  logic [1:0][TAG_W-1:0]            wb_tag;
  logic                             flush_valid;
  logic [ALT_W-1:0]                 flush_tag;
  logic [ALT_W-1:0]                 al_head;
  logic [1:0]                       iss_valid;
  logic [1:0][OP_W-1:0]             iss_op;
  logic [1:0][NSRC-1:0][TAG_W-1:0]  iss_src;
  logic [1:0][TAG_W-1:0]            iss_dst;
  logic [1:0][ALT_W-1:0]            iss_alt;

  int n_checks = 0;
  int n_errors = 0;

  always #4 clk = ~clk;

  iq_issue_queue u_dut (
    .clk(clk), .rst_n(rst_n),
    .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_op(disp_op),
    .disp_src(disp_src), .disp_src_rdy(disp_src_rdy), .disp_dst(disp_dst),
    .disp_alt(disp_alt), .wb_valid(wb_valid), .wb_tag(wb_tag),
    .flush_valid(flush_valid), .flush_tag(flush_tag), .al_head(al_head),
    .iss_valid(iss_valid), .iss_op(iss_op), .iss_src(iss_src),
    .iss_dst(iss_dst), .iss_alt(iss_alt)
  );

  typedef struct packed {
    logic       d0; logic [4:0] a0; logic r0; logic [5:0] t0;
    logic       d1; logic [4:0] a1;
    logic       wv; logic [5:0] wt;
    logic [1:0] ev; logic [4:0] e0; logic [4:0] e1;
  } vec_t;

  localparam vec_t VEC [0:18] = '{
    '{1'b1, 5'd1,  1'b0, 6'd10, 1'b0, 5'd0,  1'b0, 6'd0,  2'b00, 5'd0,  5'd0},
    '{1'b1, 5'd2,  1'b0, 6'd11, 1'b0, 5'd0,  1'b0, 6'd0,  2'b00, 5'd0,  5'd0},
    '{1'b1, 5'd3,  1'b1, 6'd12, 1'b0, 5'd0,  1'b0, 6'd0,  2'b00, 5'd0,  5'd0},
    '{1'b0, 5'd0,  1'b0, 6'd0,  1'b0, 5'd0,  1'b0, 6'd0,  2'b01, 5'd3,  5'd0},
    '{1'b0, 5'd0,  1'b0, 6'd0,  1'b0, 5'd0,  1'b1, 6'd11, 2'b00, 5'd0,  5'd0},
    '{1'b0, 5'd0,  1'b0, 6'd0,  1'b0, 5'd0,  1'b1, 6'd10, 2'b01, 5'd2,  5'd0},
    '{1'b0, 5'd0,  1'b0, 6'd0,  1'b0, 5'd0,  1'b0, 6'd0,  2'b01, 5'd1,  5'd0},
    '{1'b1, 5'd4,  1'b1, 6'd13, 1'b0, 5'd0,  1'b0, 6'd0,  2'b00, 5'd0,  5'd0},
    '{1'b0, 5'd0,  1'b0, 6'd0,  1'b0, 5'd0,  1'b0, 6'd0,  2'b01, 5'd4,  5'd0},
    '{1'b1, 5'd5,  1'b0, 6'd20, 1'b0, 5'd0,  1'b1, 6'd20, 2'b00, 5'd0,  5'd0},
    '{1'b1, 5'd6,  1'b1, 6'd14, 1'b0, 5'd0,  1'b0, 6'd0,  2'b01, 5'd5,  5'd0},
    '{1'b1, 5'd7,  1'b1, 6'd15, 1'b0, 5'd0,  1'b0, 6'd0,  2'b01, 5'd6,  5'd0},
    '{1'b1, 5'd8,  1'b1, 6'd16, 1'b0, 5'd0,  1'b0, 6'd0,  2'b01, 5'd7,  5'd0},
    '{1'b0, 5'd0,  1'b0, 6'd0,  1'b0, 5'd0,  1'b0, 6'd0,  2'b01, 5'd8,  5'd0},
    '{1'b1, 5'd9,  1'b0, 6'd30, 1'b1, 5'd10, 1'b0, 6'd0,  2'b00, 5'd0,  5'd0},
    '{1'b1, 5'd11, 1'b1, 6'd17, 1'b1, 5'd12, 1'b0, 6'd0,  2'b01, 5'd10, 5'd0},
    '{1'b0, 5'd0,  1'b0, 6'd0,  1'b0, 5'd0,  1'b1, 6'd30, 2'b11, 5'd11, 5'd12},
    '{1'b0, 5'd0,  1'b0, 6'd0,  1'b0, 5'd0,  1'b0, 6'd0,  2'b01, 5'd9,  5'd0},
    '{1'b0, 5'd0,  1'b0, 6'd0,  1'b0, 5'd0,  1'b0, 6'd0,  2'b00, 5'd0,  5'd0}
  };

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle();
    disp_valid   = '0;
    disp_op      = '0;
    disp_src     = '0;
    disp_src_rdy = '1;
    disp_dst     = '0;
    disp_alt     = '0;
    wb_valid     = '0;
    wb_tag       = '0;
    flush_valid  = 1'b0;
    flush_tag    = '0;
  endtask

  // lane l: alt tag a, source 0 tag t with ready r, other sources ready
  task automatic put(input int l, input int a, input int t, input logic r);
    disp_valid[l]      = 1'b1;
    disp_alt[l]        = ALT_W'(a);
    disp_op[l]         = OP_W'(a);
    disp_dst[l]        = TAG_W'(a + 32);
    disp_src[l]        = '0;
    disp_src[l][0]     = TAG_W'(t);
    disp_src_rdy[l]    = 3'b110 | {2'b00, r};
  endtask

  task automatic cyc();
    @(negedge clk);
    idle();
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
  endtask

  initial begin
    #(8 * 150000);
    n_errors++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    idle();
    al_head = '0;
    rst_n   = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset iss_valid", int'(iss_valid), 0);
    check("R1 reset disp_ready", int'(disp_ready), 1);
    rst_n = 1'b1;

    // table walk: R2 R3 R4 R5 R6 R7
    for (int v = 0; v < 19; v++) begin
      cyc();
      if (VEC[v].d0) put(0, VEC[v].a0, VEC[v].t0, VEC[v].r0);
      if (VEC[v].d1) put(1, VEC[v].a1, 63, 1'b1);
      wb_valid[0] = VEC[v].wv;
      wb_tag[0]   = VEC[v].wt;
      #1;
      check("R3/R4/R5 iss_valid row", int'(iss_valid), int'(VEC[v].ev));
      if (VEC[v].ev[0]) begin
        check("R6 lane0 alt", int'(iss_alt[0]), int'(VEC[v].e0));
        check("R6 lane0 dst", int'(iss_dst[0]), int'(VEC[v].e0) + 32);
        check("R6 lane0 op",  int'(iss_op[0]),  int'(VEC[v].e0));
      end
      if (VEC[v].ev[1]) check("R6 lane1 alt", int'(iss_alt[1]), int'(VEC[v].e1));
    end

    // fill to capacity: R2 stall threshold
    for (int c = 0; c < 8; c++) begin
      cyc();
      #1;
      check("R2 disp_ready while filling", int'(disp_ready), 1);
      put(0, 2 * c, 40, 1'b0);
      put(1, 2 * c + 1, 40, 1'b0);
    end
    cyc();
    #1;
    check("R2 disp_ready when full", int'(disp_ready), 0);
    put(0, 20, 12, 1'b1); // R10 refused dispatch, ready operand
    #1;
    check("R3 nothing ready when full", int'(iss_valid), 0);
    cyc();
    flush_valid = 1'b1;    // R8 flush with branch tag 7, head 0
    flush_tag   = 5'd7;
    #1;
    check("R9 no issue in flush", int'(iss_valid), 0);
    cyc();
    #1;
    check("R8 space after flush", int'(disp_ready), 1);
    wb_valid[0] = 1'b1;
    wb_tag[0]   = 6'd40;
    for (int p = 0; p < 4; p++) begin
      cyc();
      #1;
      check("R7/R8 survivor pair valid", int'(iss_valid), 3);
      check("R8 survivor lane0", int'(iss_alt[0]), 2 * p);
      check("R8 survivor lane1", int'(iss_alt[1]), 2 * p + 1);
    end
    cyc();
    #1;
    check("R10 refused dispatch left nothing", int'(iss_valid), 0);

    // age wrap: head 20, branch 25
    cyc();
    al_head = 5'd20;
    put(0, 22, 41, 1'b0);
    put(1, 28, 41, 1'b0);
    cyc();
    put(0, 3, 41, 1'b0);
    cyc();
    flush_valid = 1'b1;
    flush_tag   = 5'd25;
    put(0, 30, 12, 1'b1);  // R9 dropped
    wb_valid[0] = 1'b1;
    wb_tag[0]   = 6'd41;
    cyc();
    #1;
    check("R8 wrap survivor valid", int'(iss_valid), 1);
    check("R8 wrap survivor alt", int'(iss_alt[0]), 22);
    cyc();
    #1;
    check("R9 flush-cycle dispatch dropped", int'(iss_valid), 0);

    // R5 second writeback port, source 2 woken on entry
    cyc();
    al_head = '0;
    put(0, 9, 63, 1'b1);
    disp_src[0][2]     = 6'd50;
    disp_src_rdy[0][2] = 1'b0;
    wb_valid[1] = 1'b1;
    wb_tag[1]   = 6'd50;
    cyc();
    #1;
    check("R5 wake on entry port 1", int'(iss_valid), 1);
    check("R5 wake on entry src", int'(iss_src[0][2]), 50);
    cyc();
    #1;
    check("R7 issued once", int'(iss_valid), 0);

    summary();
    $finish;
  end
endmodule